// File: doc/BRIEF.md
# Sector Read DMA Sequencer

This block is the front end of a storage controller for sector reads. The host programs it through a small register port: a logical block number, a destination byte address in main memory, and then a command word. On a valid read command the block converts the logical block number into a (surface, track, sector) position using a geometry fixed at compile time. It fetches the words of that sector from a behavioural media model and streams them to main memory through a DMA write port, one word per beat, without the processor taking part.

When the last word of the sector has been accepted by memory, the block raises a level interrupt. The interrupt stays up until the host clears it through the status register. Bad commands, commands issued while a transfer is running and out-of-range block numbers are refused, and each of them sets a sticky error bit.

Top module: `blkrd_dma_top`

## Requirements
- R1: After reset the status register reads 0, `irq` is low and `dma_valid` is low.
- R2: Register offsets on `host_addr` are 0 command, 1 logical block number, 2 destination address, 3 status. Status bit 0 is busy, bit 1 is done, bit 2 is error. `host_rdata` shows the register selected by `host_addr` one cycle after the address is presented.
- R3: A write of code 0x01 in bits [7:0] of the command register starts a transfer when the block is idle and the block number is in range. While idle, any other code starts nothing and sets error.
- R4: With S sectors per track and T tracks per surface, the block reads sector = lbn mod S, track = (lbn div S) mod T, and surface = lbn div (S*T). With the defaults S=5, T=4 and 2 surfaces, there are 40 blocks.
- R5: In the media model, word w of position (surface, track, sector) is the 32-bit value {surface XOR 0x5A, track, sector, w}, one byte each, with surface in the most significant byte.
- R6: A transfer moves one 512-byte sector as 128 words, in ascending order. Word w goes to byte address dest + 4*w.
- R7: While `dma_valid` is high and `dma_ready` is low, `dma_valid`, `dma_addr` and `dma_data` hold their values.
- R8: When memory accepts the last word, busy clears and done sets, both on that clock edge. `irq` equals done.
- R9: Writing status with bit 1 set clears done and `irq`. Writing status with bit 2 set clears error. Zero bits leave their flags alone.
- R10: A command write while busy is ignored and sets error. The running transfer, and any writes made during it to the block number or destination registers, do not change the words sent or their addresses.
- R11: A read command with a block number of 40 or more (the total block count) starts no transfer and sets error.
- R12: If the last word is accepted in the same cycle that the host writes status to clear done, done is set afterwards and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| dma_valid | output | 1 | DMA write word present |
| dma_addr | output | 32 | DMA byte address |
| dma_data | output | 32 | DMA write word |
| dma_ready | input | 1 | Memory accepts the word this cycle |
| irq | output | 1 | Transfer-complete interrupt, level |

## Verification
The done flag has two sources: the final accepted DMA beat sets it, and a host status write clears it. Both can arrive on the same clock edge. The bench holds `dma_ready` low once 127 words have been accepted. When the 128th word is presented, it raises `dma_ready` and, in that same cycle, writes the clear-done bit. It then reads status and expects done set, busy clear and `irq` high. A plain clear afterwards must drop `irq`, which shows that the set won only because the two events coincided.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;
  localparam int GEO_W = 8;
  localparam logic [7:0] CMD_READ = 8'h01;
  localparam logic [GEO_W-1:0] MEDIA_SALT = 8'h5A;
  localparam int ST_BUSY_BIT = 0;
  localparam int ST_DONE_BIT = 1;
  localparam int ST_ERR_BIT  = 2;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_LBN  = 2'd1,
    REG_DEST = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [GEO_W-1:0] surf;
    logic [GEO_W-1:0] trk;
    logic [GEO_W-1:0] sec;
  } chs_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SEND
  } dma_st_e;
endpackage

// File: rtl/blkrd_xlate.sv
module blkrd_xlate
  import blkrd_pkg::*;
#(
  parameter int LBN_W   = 32,
  parameter int SECTORS = 5,
  parameter int TRACKS  = 4
) (
  input  logic [LBN_W-1:0] lbn,
  output chs_t             chs
);
  logic [LBN_W-1:0] quo_s;
  logic [LBN_W-1:0] rem_s;
  logic [LBN_W-1:0] rem_t;
  logic [LBN_W-1:0] quo_t;

  always_comb begin
    rem_s    = lbn % LBN_W'(SECTORS);
    quo_s    = lbn / LBN_W'(SECTORS);
    rem_t    = quo_s % LBN_W'(TRACKS);
    quo_t    = quo_s / LBN_W'(TRACKS);
    chs.sec  = GEO_W'(rem_s);
    chs.trk  = GEO_W'(rem_t);
    chs.surf = GEO_W'(quo_t);
  end
endmodule

// File: rtl/blkrd_media.sv
module blkrd_media
  import blkrd_pkg::*;
#(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rd,
  input  chs_t              chs,
  input  logic [WIDX_W-1:0] widx,
  output logic [DATA_W-1:0] data_q
);
  logic [DATA_W-1:0] word_c;

  // Media content is a pure function of position, so no array is stored.
  always_comb begin
    word_c = DATA_W'({chs.surf ^ MEDIA_SALT, chs.trk, chs.sec, GEO_W'(widx)});
  end

  always_ff @(posedge clk) begin
    if (rd) data_q <= word_c;
  end
endmodule

// File: rtl/blkrd_regs.sv
module blkrd_regs
  import blkrd_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int TOTAL_BLOCKS = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              busy,
  input  logic              done_set,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] lbn_q,
  output logic [ADDR_W-1:0] dest_q,
  output logic              start,
  output logic              err_q,
  output logic              done_q
);
  logic cmd_wr;
  logic stat_wr;
  logic code_ok;
  logic lbn_ok;
  logic reject;
  logic [DATA_W-1:0] stat_v;

  always_comb begin
    cmd_wr  = host_we && (host_addr == REG_CMD);
    stat_wr = host_we && (host_addr == REG_STAT);
    code_ok = (host_wdata[7:0] == CMD_READ);
    lbn_ok  = (lbn_q < DATA_W'(TOTAL_BLOCKS));
    start   = cmd_wr && code_ok && lbn_ok && !busy;
    reject  = cmd_wr && !start;
    stat_v  = '0;
    stat_v[ST_BUSY_BIT] = busy;
    stat_v[ST_DONE_BIT] = done_q;
    stat_v[ST_ERR_BIT]  = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lbn_q      <= '0;
      dest_q     <= '0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_we && host_addr == REG_LBN)  lbn_q  <= host_wdata;
      if (host_we && host_addr == REG_DEST) dest_q <= host_wdata[ADDR_W-1:0];
      if (done_set)
        done_q <= 1'b1;
      else if (stat_wr && host_wdata[ST_DONE_BIT])
        done_q <= 1'b0;
      if (reject)
        err_q <= 1'b1;
      else if (stat_wr && host_wdata[ST_ERR_BIT])
        err_q <= 1'b0;
      case (host_addr)
        REG_LBN:  host_rdata <= lbn_q;
        REG_DEST: host_rdata <= DATA_W'(dest_q);
        REG_STAT: host_rdata <= stat_v;
        default:  host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/blkrd_dma.sv
module blkrd_dma
  import blkrd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORDS  = 128,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int STEP   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  chs_t              chs_in,
  input  logic [ADDR_W-1:0] dest_in,
  output logic              busy,
  output logic              done_set,
  output logic              med_rd,
  output chs_t              med_chs,
  output logic [WIDX_W-1:0] med_widx,
  input  logic [DATA_W-1:0] med_data,
  output logic              dma_valid,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_data,
  input  logic              dma_ready
);
  dma_st_e st_q;
  logic    last;
  logic    beat;

  always_comb begin
    last     = (med_widx == WIDX_W'(WORDS - 1));
    beat     = (st_q == ST_SEND) && dma_ready;
    done_set = beat && last;
    med_rd   = (st_q == ST_FETCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      busy      <= 1'b0;
      med_chs   <= '0;
      med_widx  <= '0;
      dma_valid <= 1'b0;
      dma_addr  <= '0;
      dma_data  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            med_chs  <= chs_in;
            dma_addr <= dest_in;
            med_widx <= '0;
            busy     <= 1'b1;
            st_q     <= ST_FETCH;
          end
        end
        ST_FETCH: st_q <= ST_LOAD;
        ST_LOAD: begin
          dma_data  <= med_data;
          dma_valid <= 1'b1;
          st_q      <= ST_SEND;
        end
        ST_SEND: begin
          if (beat) begin
            dma_valid <= 1'b0;
            if (last) begin
              busy <= 1'b0;
              st_q <= ST_IDLE;
            end else begin
              med_widx <= med_widx + 1'b1;
              dma_addr <= dma_addr + ADDR_W'(STEP);
              st_q     <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkrd_dma_top.sv
module blkrd_dma_top
  import blkrd_pkg::*;
#(
  parameter int SURFACES     = 2,
  parameter int TRACKS       = 4,
  parameter int SECTORS      = 5,
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dma_valid,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_data,
  input  logic              dma_ready,
  output logic              irq
);
  localparam int WORDS        = SECTOR_BYTES / (DATA_W / 8);
  localparam int WIDX_W       = $clog2(WORDS);
  localparam int TOTAL_BLOCKS = SURFACES * TRACKS * SECTORS;

  logic [DATA_W-1:0] lbn_w;
  logic [ADDR_W-1:0] dest_w;
  logic              start_w;
  logic              busy_w;
  logic              done_set_w;
  logic              err_w;
  logic              done_w;
  chs_t              chs_w;
  chs_t              med_chs_w;
  logic              med_rd_w;
  logic [WIDX_W-1:0] med_widx_w;
  logic [DATA_W-1:0] med_data_w;

  assign irq = done_w;

  blkrd_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOTAL_BLOCKS(TOTAL_BLOCKS)
  ) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy_w), .done_set(done_set_w),
    .host_rdata(host_rdata), .lbn_q(lbn_w), .dest_q(dest_w),
    .start(start_w), .err_q(err_w), .done_q(done_w)
  );

  blkrd_xlate #(
    .LBN_W(DATA_W), .SECTORS(SECTORS), .TRACKS(TRACKS)
  ) u_xlate (
    .lbn(lbn_w), .chs(chs_w)
  );

  blkrd_media #(
    .WORDS(WORDS), .DATA_W(DATA_W)
  ) u_media (
    .clk(clk), .rd(med_rd_w), .chs(med_chs_w), .widx(med_widx_w),
    .data_q(med_data_w)
  );

  blkrd_dma #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)
  ) u_dma (
    .clk(clk), .rst(rst), .start(start_w), .chs_in(chs_w), .dest_in(dest_w),
    .busy(busy_w), .done_set(done_set_w), .med_rd(med_rd_w),
    .med_chs(med_chs_w), .med_widx(med_widx_w), .med_data(med_data_w),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_data(dma_data),
    .dma_ready(dma_ready)
  );
endmodule

// File: rtl/blkrd_chk.sv
module blkrd_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [1:0]        host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              dma_valid,
  input logic              dma_ready,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [DATA_W-1:0] dma_data,
  input logic              irq,
  input logic              busy,
  input logic              err
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_data));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !(host_we && host_addr == 2'd3 && host_wdata[1]) |=> irq);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(dma_valid && dma_ready));

  // R10
  busy_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
    host_we && host_addr == 2'd0 && busy |=> err);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dma_valid);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);
endmodule

bind blkrd_dma_top blkrd_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .dma_valid(dma_valid), .dma_ready(dma_ready),
  .dma_addr(dma_addr), .dma_data(dma_data), .irq(irq), .busy(busy_w),
  .err(err_w)
);

// File: tb/sim_blkrd_dma_top.sv
module sim_blkrd_dma_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        dma_valid;
  logic [31:0] dma_addr;
  logic [31:0] dma_data;
  logic        dma_ready;
  logic        irq;

  logic        pat_ready = 1'b1;
  logic        force_mode = 1'b0;
  logic        force_val = 1'b0;
  int          rmode = 0;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          beat_total = 0;
  int          bad_total = 0;
  int          stall_bad = 0;
  int          beat_base = 0;
  int          bad_base = 0;
  logic [31:0] cur_lbn = 0;
  logic [31:0] cur_dest = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = 0;
  logic [31:0] prev_data = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  assign dma_ready = force_mode ? force_val : pat_ready;

  blkrd_dma_top u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dma_valid(dma_valid),
    .dma_addr(dma_addr), .dma_data(dma_data), .dma_ready(dma_ready), .irq(irq)
  );

  // Expected media word, from R4 and R5.
  function automatic logic [31:0] exp_word(input logic [31:0] lbn, input int w);
    logic [31:0] q;
    logic [7:0]  s, t, f;
    q = lbn / 5;
    s = 8'(lbn % 5);
    t = 8'(q % 4);
    f = 8'(q / 4);
    return {f ^ 8'h5A, t, s, 8'(w)};
  endfunction

  always @(negedge clk) begin
    cyc++;
    pat_ready = (rmode == 0) || (cyc % 3 != 0);
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (prev_stall && (!dma_valid || dma_addr != prev_addr || dma_data != prev_data))
        stall_bad <= stall_bad + 1;
      prev_stall <= dma_valid && !dma_ready;
      prev_addr  <= dma_addr;
      prev_data  <= dma_data;
      if (dma_valid && dma_ready) begin
        if (dma_addr != cur_dest + 32'(4 * (beat_total - beat_base)) ||
            dma_data != exp_word(cur_lbn, beat_total - beat_base))
          bad_total <= bad_total + 1;
        beat_total <= beat_total + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  // {lbn, dest, ready mode}
  localparam logic [71:0] VEC [5] = '{
    {32'd0,  32'h0000_1000, 8'd0},
    {32'd23, 32'h0000_2000, 8'd1},
    {32'd39, 32'h0000_3FF0, 8'd1},
    {32'd7,  32'h0000_4004, 8'd0},
    {32'd14, 32'h8000_0000, 8'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rdreg(2'd3, rd);
    check(rd == 32'd0, "R1 status", rd, 32'd0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
    check(dma_valid == 1'b0, "R1 dma_valid", 32'(dma_valid), 32'd0);

    for (int v = 0; v < 5; v++) begin
      cur_lbn  = VEC[v][71:40];
      cur_dest = VEC[v][39:8];
      rmode    = int'(VEC[v][7:0]);
      beat_base = beat_total;
      bad_base  = bad_total;
      wr(2'd1, cur_lbn);
      wr(2'd2, cur_dest);
      rdreg(2'd2, rd);
      check(rd == cur_dest, "R2 dest readback", rd, cur_dest);
      wr(2'd0, 32'h1);
      rdreg(2'd3, rd);
      check(rd[0] == 1'b1, "R2 R3 busy after start", rd, 32'h1);
      wait_irq();
      @(negedge clk);
      check(beat_total - beat_base == 128, "R6 beat count", 32'(beat_total - beat_base), 32'd128);
      check(bad_total == bad_base, "R4 R5 R6 words and addresses", 32'(bad_total - bad_base), 32'd0);
      rdreg(2'd3, rd);
      check(rd == 32'h2 && irq, "R8 done status", rd, 32'h2);
      wr(2'd3, 32'h2);
      rdreg(2'd3, rd);
      check(rd == 32'h0 && !irq, "R9 clear done", rd, 32'h0);
    end
    check(stall_bad == 0, "R7 stall hold", 32'(stall_bad), 32'd0);

    // R10 command and register writes while busy
    cur_lbn = 32'd7; cur_dest = 32'h0000_5000; rmode = 1;
    beat_base = beat_total; bad_base = bad_total;
    wr(2'd1, cur_lbn);
    wr(2'd2, cur_dest);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'd30);
    wr(2'd2, 32'h0000_9000);
    wr(2'd0, 32'h1);
    rdreg(2'd3, rd);
    check(rd == 32'h5, "R10 busy and error", rd, 32'h5);
    wait_irq();
    @(negedge clk);
    check(beat_total - beat_base == 128, "R10 beat count", 32'(beat_total - beat_base), 32'd128);
    check(bad_total == bad_base, "R10 transfer unchanged", 32'(bad_total - bad_base), 32'd0);
    wr(2'd3, 32'h6);
    rdreg(2'd3, rd);
    check(rd == 32'h0, "R9 clear error and done", rd, 32'h0);

    // R3 unknown command code while idle
    beat_base = beat_total;
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h2);
    repeat (8) @(negedge clk);
    rdreg(2'd3, rd);
    check(rd == 32'h4, "R3 bad code sets error only", rd, 32'h4);
    check(beat_total == beat_base, "R3 bad code no beats", 32'(beat_total - beat_base), 32'd0);
    wr(2'd3, 32'h4);
    rdreg(2'd3, rd);
    check(rd == 32'h0, "R9 clear error", rd, 32'h0);

    // R11 block number at the limit
    wr(2'd1, 32'd40);
    wr(2'd0, 32'h1);
    repeat (8) @(negedge clk);
    rdreg(2'd3, rd);
    check(rd == 32'h4, "R11 out of range error", rd, 32'h4);
    check(beat_total == beat_base && !irq, "R11 no transfer", 32'(beat_total - beat_base), 32'd0);
    wr(2'd3, 32'h4);

    // R12 done set meets done clear
    cur_lbn = 32'd11; cur_dest = 32'h0000_6000; rmode = 0;
    beat_base = beat_total; bad_base = bad_total;
    wr(2'd1, cur_lbn);
    wr(2'd2, cur_dest);
    wr(2'd0, 32'h1);
    for (int i = 0; i < 3000 && (beat_total - beat_base) < 127; i++) @(negedge clk);
    force_val = 1'b0; force_mode = 1'b1;
    for (int i = 0; i < 20 && !dma_valid; i++) @(negedge clk);
    force_val = 1'b1;
    host_we = 1'b1; host_addr = 2'd3; host_wdata = 32'h2;
    @(negedge clk);
    host_we = 1'b0; force_mode = 1'b0;
    rdreg(2'd3, rd);
    check(rd == 32'h2 && irq, "R12 set wins over clear", rd, 32'h2);
    check(bad_total == bad_base && beat_total - beat_base == 128, "R12 transfer complete",
          32'(beat_total - beat_base), 32'd128);
    wr(2'd3, 32'h2);
    rdreg(2'd3, rd);
    check(rd == 32'h0 && !irq, "R12 later clear drops irq", rd, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule